// File: doc/BRIEF.md
# Half-Width SDRAM Data Bus Sequencer

This block connects a 32-bit internal data path to an external SDRAM data bus that can be 32 or 16 bits wide, chosen separately for each of four channels. It moves data only; commands, addresses, refresh and timing belong to other logic. The internal side presents one request at a time: channel, direction, byte enables and write data. The request is held until a single-cycle acknowledge.

On a 32-bit channel the word goes out as one external beat on all lanes. On a 16-bit channel the block always issues two beats on the low lanes, even when only one byte is enabled. An endian mode input sets the order of the two beats. Each beat carries its own byte masks, and the masks for the upper lanes are held high. For reads, the two returned half-words are put back into one 32-bit word, which is delivered with the acknowledge. Each external beat completes when the beat interface asserts ready.

Top module: `sdram_halfbus_seq`

## Requirements
- R1: Each channel has a width bit `width_cfg[ch]`, where 1 selects a 16-bit external bus and 0 selects a 32-bit bus. The bit for the requested channel is sampled when the request is accepted. `bt_chan` carries that channel on every beat.
- R2: A 16-bit channel issues exactly two beats per request, whatever the byte enables. A 32-bit channel issues exactly one beat, with `bt_wdata` equal to the full write word and `bt_mask` equal to the inverse of `req_be`. `bt_last` is high only on the final beat.
- R3: On a 16-bit channel, the half that a beat carries is placed on `bt_wdata[15:0]`. With `big_endian`=1 the first beat carries internal bits [31:16] and the second carries [15:0]. With `big_endian`=0 the order is reversed.
- R4: On a 16-bit beat, `bt_mask[3:2]` is 2'b11. `bt_mask[1:0]` is the inverse of the byte enables for the half being carried: `req_be[3:2]` for bits [31:16] and `req_be[1:0]` for bits [15:0]. A mask bit of 1 suppresses a byte.
- R5: `bt_drive` (the output enable for all data lanes, including the upper lanes) is 1 on write beats and 0 on read beats, so the upper lanes are high impedance during reads.
- R6: For a read, `rd_valid` pulses in the same cycle as `req_ack`. On a 16-bit channel, `rd_data` holds the two returned low-lane half-words, placed back at the internal positions given by the endian order. On a 32-bit channel, `rd_data` holds the returned word.
- R7: `req_ack` is a one-cycle pulse in the cycle after the final beat's handshake. No new request is accepted while a transfer is in progress or during the acknowledge cycle.
- R8: The endian mode, the width, the write data and the byte enables are captured at acceptance. Changes to them between the two beats do not affect the second beat.
- R9: While `bt_valid` is high and `bt_ready` is low, the beat outputs hold their values.
- R10: During and right after reset, `bt_valid`, `req_ack` and `rd_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| width_cfg | input | 4 | Per-channel width select, 1 = 16-bit |
| big_endian | input | 1 | Beat order select |
| req_valid | input | 1 | Internal request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_chan | input | 2 | Target channel |
| req_be | input | 4 | Byte enables, active high |
| req_wdata | input | 32 | Write word |
| req_ack | output | 1 | Request done pulse |
| rd_valid | output | 1 | Read word valid pulse |
| rd_data | output | 32 | Reassembled read word |
| bt_valid | output | 1 | External beat pending |
| bt_ready | input | 1 | Beat completes this cycle |
| bt_write | output | 1 | Beat direction |
| bt_last | output | 1 | Final beat of the request |
| bt_chan | output | 2 | Beat channel |
| bt_wdata | output | 32 | Beat write lanes |
| bt_mask | output | 4 | Byte masks, 1 = suppress |
| bt_drive | output | 1 | Data lane output enable |
| bt_rdata | input | 32 | Returned read lanes |

## Verification
On every cycle, the assertions check four things: the upper masks stay high on 16-bit beats, a 16-bit first beat is always followed by a second beat and not by an acknowledge, the beat outputs hold during wait states, and the acknowledge and read-valid pulse correctly. Only the bench scenarios can show the lane contents and beat order for each endian mode, the reassembled read words, and whether later input changes are ignored. The bench covers per-channel width mixes, partial byte enables, and mid-transfer changes to the mode, width and data.

// File: rtl/sdram_halfbus_seq.sv
module sdram_halfbus_seq #(
  parameter int NCH = 4,
  parameter int DW  = 32,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int BW = DW / 8,
  localparam int HW = DW / 2,
  localparam int HB = BW / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NCH-1:0] width_cfg,
  input  logic          big_endian,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [CW-1:0] req_chan,
  input  logic [BW-1:0] req_be,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ack,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          bt_valid,
  input  logic          bt_ready,
  output logic          bt_write,
  output logic          bt_last,
  output logic [CW-1:0] bt_chan,
  output logic [DW-1:0] bt_wdata,
  output logic [BW-1:0] bt_mask,
  output logic          bt_drive,
  input  logic [DW-1:0] bt_rdata
);

  typedef enum logic [1:0] {ST_IDLE, ST_B0, ST_B1} st_t;
  st_t st;

  logic [DW-1:0] wdata_q;
  logic [BW-1:0] be_q;
  logic [CW-1:0] chan_q;
  logic          wr_q, wide_q, big_q;
  logic [HW-1:0] first_q;

  wire accept = req_valid && (st == ST_IDLE) && !req_ack;
  wire hs     = bt_valid && bt_ready;
  wire second = (st == ST_B1);
  wire up_sel = big_q ^ second;

  wire [HW-1:0] half_d  = up_sel ? wdata_q[DW-1:HW] : wdata_q[HW-1:0];
  wire [HB-1:0] half_be = up_sel ? be_q[BW-1:HB] : be_q[HB-1:0];

  wire [DW-1:0] merged = wide_q ? bt_rdata :
                         big_q  ? {first_q, bt_rdata[HW-1:0]} : {bt_rdata[HW-1:0], first_q};

  assign bt_valid = (st != ST_IDLE);
  assign bt_write = wr_q;
  assign bt_chan  = chan_q;
  assign bt_last  = wide_q || second;
  assign bt_drive = bt_valid && wr_q;
  assign bt_wdata = wide_q ? wdata_q : {{HW{1'b0}}, half_d};
  assign bt_mask  = wide_q ? ~be_q : {{HB{1'b1}}, ~half_be};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      wdata_q  <= '0;
      be_q     <= '0;
      chan_q   <= '0;
      wr_q     <= 1'b0;
      wide_q   <= 1'b1;
      big_q    <= 1'b0;
      first_q  <= '0;
      req_ack  <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      req_ack  <= 1'b0;
      rd_valid <= 1'b0;
      case (st)
        ST_IDLE: if (accept) begin
          st      <= ST_B0;
          wdata_q <= req_wdata;
          be_q    <= req_be;
          chan_q  <= req_chan;
          wr_q    <= req_write;
          wide_q  <= !width_cfg[req_chan];
          big_q   <= big_endian;
        end
        ST_B0: if (hs) begin
          if (wide_q) begin
            st       <= ST_IDLE;
            req_ack  <= 1'b1;
            rd_valid <= !wr_q;
            if (!wr_q) rd_data <= merged;
          end else begin
            st      <= ST_B1;
            first_q <= bt_rdata[HW-1:0];
          end
        end
        ST_B1: if (hs) begin
          st       <= ST_IDLE;
          req_ack  <= 1'b1;
          rd_valid <= !wr_q;
          if (!wr_q) rd_data <= merged;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R4: upper byte masks held high on every half-width beat
  a_r4_upper_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (bt_valid && !bt_last) || (bt_valid && second) |-> bt_mask[BW-1:HB] == {HB{1'b1}});

  // R2: a completed half-width first beat is always followed by a second beat
  a_r2_two_beats: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && !bt_last) |=> (bt_valid && bt_last && !req_ack));

  // R9: beat outputs hold while the external side stalls
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bt_valid && !bt_ready) |=> (bt_valid && $stable(bt_wdata) && $stable(bt_mask)
                                  && $stable(bt_chan) && $stable(bt_last)));

  // R7: acknowledge is a single pulse following a final-beat handshake
  a_r7_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> !req_ack);
  a_r7_ack_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> $past(hs && bt_last));

  // R6: read-valid only together with acknowledge
  a_r6_rdv_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> req_ack);

endmodule

// File: tb/sdram_halfbus_seq_test.sv
`timescale 1ns/1ps
module sdram_halfbus_seq_test;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic [3:0]  width_cfg = 4'b0101;
  logic        big_endian = 0, req_valid = 0, req_write = 0, bt_ready = 0;
  logic [1:0]  req_chan = 0;
  logic [3:0]  req_be = 0;
  logic [31:0] req_wdata = 0, bt_rdata = 0;
  logic        req_ack, rd_valid, bt_valid, bt_write, bt_last, bt_drive;
  logic [31:0] rd_data, bt_wdata;
  logic [1:0]  bt_chan;
  logic [3:0]  bt_mask;

  sdram_halfbus_seq uut (.*);

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // {chan, write, big, be, wdata, waits}
  localparam logic [41:0] VEC [8] = '{
    {2'd0, 1'b1, 1'b1, 4'hF, 32'hAABBCCDD, 2'd0},
    {2'd0, 1'b1, 1'b0, 4'h1, 32'h11223344, 2'd1},
    {2'd2, 1'b0, 1'b1, 4'hF, 32'h89ABCDEF, 2'd0},
    {2'd2, 1'b0, 1'b0, 4'hC, 32'h0F1E2D3C, 2'd2},
    {2'd1, 1'b1, 1'b1, 4'h6, 32'hDEADBEEF, 2'd0},
    {2'd3, 1'b0, 1'b0, 4'hF, 32'h55AA33CC, 2'd1},
    {2'd0, 1'b1, 1'b1, 4'h8, 32'h01020304, 2'd0},
    {2'd2, 1'b1, 1'b0, 4'h2, 32'hCAFEF00D, 2'd0}
  };

  task automatic xfer(input logic [1:0] ch, input logic wr, input logic big,
                      input logic [3:0] be, input logic [31:0] wd, input int waits, input bit flip);
    bit nar = width_cfg[ch];
    int nb = nar ? 2 : 1;
    int beats = 0, w = waits, cyc = 0;
    bit got = 0;
    @(negedge clk);
    req_chan = ch; req_write = wr; big_endian = big; req_be = be; req_wdata = wd; req_valid = 1;
    while (!got && cyc < 200) begin
      @(negedge clk); cyc++;
      bt_ready = 0;
      if (req_ack) begin
        got = 1; req_valid = 0;
        chk(rd_valid == !wr, "R6 rd_valid", {31'b0, rd_valid}, {31'b0, !wr});
        if (!wr) chk(rd_data == wd, "R6 rd_data", rd_data, wd);
      end else if (bt_valid) begin
        if (w > 0) w--;
        else begin
          bit up = big ^ (beats == 1);
          logic [15:0] h = up ? wd[31:16] : wd[15:0];
          logic [1:0] hb = up ? be[3:2] : be[1:0];
          chk(beats < nb, "R2 extra beat", beats, nb);
          chk(bt_chan == ch, "R1 chan", {30'b0, bt_chan}, {30'b0, ch});
          chk(bt_last == (beats == nb - 1), "R2 last", {31'b0, bt_last}, {31'b0, beats == nb - 1});
          chk(bt_drive == wr, "R5 drive", {31'b0, bt_drive}, {31'b0, wr});
          if (nar) begin
            chk(bt_mask == {2'b11, ~hb}, "R4 mask", {28'b0, bt_mask}, {28'b0, 2'b11, ~hb});
            if (wr) chk(bt_wdata[15:0] == h, "R3 lane data", {16'b0, bt_wdata[15:0]}, {16'b0, h});
            bt_rdata = {16'hBEEF, h};
          end else begin
            chk(bt_mask == ~be, "R2 wide mask", {28'b0, bt_mask}, {28'b0, ~be});
            if (wr) chk(bt_wdata == wd, "R2 wide data", bt_wdata, wd);
            bt_rdata = wd;
          end
          bt_ready = 1; beats++; w = waits;
          if (flip && beats == 1) begin
            big_endian = ~big_endian; width_cfg = ~width_cfg;
            req_wdata = ~req_wdata; req_be = ~req_be;
          end
        end
      end
    end
    chk(got, "R7 ack seen", {31'b0, got}, 1);
    chk(beats == nb, "R2 beat count", beats, nb);
    @(negedge clk);
    chk(!req_ack && !bt_valid, "R7 single ack", {30'b0, req_ack, bt_valid}, 0);
    if (flip) width_cfg = ~width_cfg;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!bt_valid && !req_ack && !rd_valid, "R10 reset", {29'b0, bt_valid, req_ack, rd_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!bt_valid && !req_ack && !rd_valid, "R10 after reset", {29'b0, bt_valid, req_ack, rd_valid}, 0);
    foreach (VEC[i]) begin
      xfer(VEC[i][41:40], VEC[i][39], VEC[i][38], VEC[i][37:34], VEC[i][33:2], int'(VEC[i][1:0]), 0);
    end
    // R8: mode, width, data and enables changed between beats
    xfer(2'd0, 1'b1, 1'b1, 4'h7, 32'h13572468, 0, 1);
    xfer(2'd2, 1'b0, 1'b0, 4'hF, 32'h2468ACE0, 1, 1);
    // R1: width remap at run time
    width_cfg = 4'b1010;
    xfer(2'd0, 1'b1, 1'b0, 4'hF, 32'h0BADCAFE, 0, 0);
    xfer(2'd1, 1'b0, 1'b1, 4'hF, 32'h7E57DA7A, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  int wd_cnt = 0;
  always @(posedge clk) begin
    wd_cnt++;
    if (wd_cnt > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", wd_cnt, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule